// File: doc/BRIEF.md
# CEC Bit Transmitter with Adjustable Period

This block turns a stream of bit requests into timed low and high phases on an open-drain single-wire CEC line. Each request is either a start bit or a data bit carrying a value, and it arrives on a valid/ready handshake. The block pulls the line low for the low phase that the request calls for and then lets it go. The bit ends when the next falling edge is due. At that point the next request is taken up at once, or the line stays released and the block goes idle.

A 2-bit advance select moves that ending edge earlier by a fixed number of ticks. The advance for start bits differs from the advance for data bits. The select is captured when a burst of bits begins from idle, and it keeps that value until the block returns to idle.

All timing is counted on a tick enable supplied from outside, nominally one tick every 10 µs. The defaults are: a start bit low for 370 ticks in a 450-tick period, and a data bit low for 150 ticks (value 0) or 60 ticks (value 1) in a 240-tick period.

Top module: `cec_bit_tx`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the line is released (`drive_low` = 0) and `bit_ready` = 1.
- R2: A start bit (`bit_start` = 1) holds `drive_low` high for START_LOW ticks, beginning the cycle after it is accepted.
- R3: A data bit with `bit_value` = 0 holds `drive_low` high for ZERO_LOW ticks.
- R4: A data bit with `bit_value` = 1 holds `drive_low` high for ONE_LOW ticks.
- R5: With advance select 0, a bit lasts its full period: START_PER ticks for a start bit, DATA_PER ticks for a data bit.
- R6: With advance select k = 1, 2 or 3, a start bit lasts START_PER − START_ADV[k] ticks.
- R7: With advance select k = 1, 2 or 3, a data bit lasts DATA_PER − DATA_ADV[k] ticks.
- R8: The advance select is sampled only when a bit is accepted from idle. Changing it while bits are in progress does not alter any bit until the block has been idle again.
- R9: `bit_ready` is 1 only while the block is idle or during the final tick cycle of a bit. It is 0 for the whole low phase.
- R10: A request that is valid at the final tick cycle of a bit is accepted there, and its low phase starts on the very next cycle, with no released cycle in between.
- R11: Timing advances only on cycles with `tick` = 1. While `tick` = 0, the phase in progress does not end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Time-base enable, one pulse per tick |
| bit_valid | input | 1 | A bit request is offered |
| bit_start | input | 1 | 1 = start bit, 0 = data bit |
| bit_value | input | 1 | Data bit value, ignored for start bits |
| adv_sel | input | 2 | Advance select for the falling edge that ends each bit |
| bit_ready | output | 1 | Request is taken this cycle if valid |
| drive_low | output | 1 | Open-drain enable: 1 pulls the line low |

## Verification
The bench builds the block with short timings: START_LOW 8, START_PER 12, ZERO_LOW 5, ONE_LOW 2, DATA_PER 10, start advances {0,1,2,3} and data advances {0,2,3,4}. With `tick` held high, every phase is then a few cycles long. This lets the bench sweep all twelve combinations of select and bit kind, and measure each low and high phase exactly in cycles. The short periods also make back-to-back bursts, a mid-burst change of select, stalled ticks and a reset in the middle of a bit quick to reach. The smallest high phase, one tick, exercises the case where the low phase hands over directly to the final tick cycle.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } tx_state_e;

  typedef struct packed {
    logic is_start;
    logic value;
  } bit_req_t;

  localparam int NUM_ADV = 4;

endpackage

// File: rtl/cec_tx_timing.sv
module cec_tx_timing
  import cec_tx_pkg::*;
#(
  parameter int CW         = 9,
  parameter int START_LOW  = 370,
  parameter int START_PER  = 450,
  parameter int ZERO_LOW   = 150,
  parameter int ONE_LOW    = 60,
  parameter int DATA_PER   = 240,
  parameter int START_ADV [NUM_ADV] = '{0, 4, 10, 16},
  parameter int DATA_ADV  [NUM_ADV] = '{0, 19, 25, 31}
) (
  input  bit_req_t        req,
  input  logic [1:0]      sel,
  output logic [CW-1:0]   low_len,
  output logic [CW-1:0]   per_len
);

  logic [CW-1:0] per_start_tab [NUM_ADV];
  logic [CW-1:0] per_data_tab  [NUM_ADV];

  for (genvar g = 0; g < NUM_ADV; g++) begin : g_adv
    localparam int PS = START_PER - START_ADV[g];
    localparam int PD = DATA_PER  - DATA_ADV[g];
    assign per_start_tab[g] = CW'(PS);
    assign per_data_tab[g]  = CW'(PD);
  end

  always_comb begin
    if (req.is_start) begin
      low_len = CW'(START_LOW);
      per_len = per_start_tab[sel];
    end else begin
      low_len = req.value ? CW'(ONE_LOW) : CW'(ZERO_LOW);
      per_len = per_data_tab[sel];
    end
  end

endmodule

// File: rtl/cec_tx_tick_cnt.sv
module cec_tx_tick_cnt #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_d;

  always_comb begin
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt + 1'b1;
    else          cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/cec_tx_ctrl.sv
module cec_tx_ctrl
  import cec_tx_pkg::*;
#(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bit_valid,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] low_len,
  input  logic [CW-1:0] per_len,
  output tx_state_e     state,
  output logic          ready,
  output logic          accept,
  output logic          cnt_clr,
  output logic          cnt_adv
);

  tx_state_e state_d;
  logic      low_done;
  logic      bit_done;

  assign low_done = (state == ST_LOW)  && tick && (cnt == low_len - 1'b1);
  assign bit_done = (state == ST_HIGH) && tick && (cnt == per_len - 1'b1);
  assign ready    = (state == ST_IDLE) || bit_done;
  assign accept   = bit_valid && ready;
  assign cnt_clr  = accept;
  assign cnt_adv  = tick && (state != ST_IDLE);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: if (accept)   state_d = ST_LOW;
      ST_LOW:  if (low_done) state_d = ST_HIGH;
      ST_HIGH: if (bit_done) state_d = accept ? ST_LOW : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

endmodule

// File: rtl/cec_bit_tx.sv
module cec_bit_tx
  import cec_tx_pkg::*;
#(
  parameter int START_LOW  = 370,
  parameter int START_PER  = 450,
  parameter int ZERO_LOW   = 150,
  parameter int ONE_LOW    = 60,
  parameter int DATA_PER   = 240,
  parameter int START_ADV [NUM_ADV] = '{0, 4, 10, 16},
  parameter int DATA_ADV  [NUM_ADV] = '{0, 19, 25, 31}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bit_valid,
  input  logic       bit_start,
  input  logic       bit_value,
  input  logic [1:0] adv_sel,
  output logic       bit_ready,
  output logic       drive_low
);

  localparam int MAX_PER = (START_PER > DATA_PER) ? START_PER : DATA_PER;
  localparam int CW      = $clog2(MAX_PER + 1);

  tx_state_e     state;
  logic          accept;
  logic          cnt_clr;
  logic          cnt_adv;
  logic [CW-1:0] cnt;
  logic [CW-1:0] low_len;
  logic [CW-1:0] per_len;
  logic          busy;

  bit_req_t      req_q, req_d;
  logic [1:0]    sel_q, sel_d;
  logic          sel_en;

  assign busy   = (state != ST_IDLE);
  assign sel_en = accept && !busy;

  always_comb begin
    req_d = req_q;
    sel_d = sel_q;
    if (accept) begin
      req_d.is_start = bit_start;
      req_d.value    = bit_value;
    end
    if (sel_en) sel_d = adv_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      sel_q <= '0;
    end else begin
      req_q <= req_d;
      sel_q <= sel_d;
    end
  end

  cec_tx_timing #(
    .CW(CW), .START_LOW(START_LOW), .START_PER(START_PER),
    .ZERO_LOW(ZERO_LOW), .ONE_LOW(ONE_LOW), .DATA_PER(DATA_PER),
    .START_ADV(START_ADV), .DATA_ADV(DATA_ADV)
  ) i_timing (
    .req(req_q), .sel(sel_q), .low_len(low_len), .per_len(per_len)
  );

  cec_tx_tick_cnt #(.CW(CW)) i_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(cnt_adv), .cnt(cnt)
  );

  cec_tx_ctrl #(.CW(CW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bit_valid(bit_valid),
    .cnt(cnt), .low_len(low_len), .per_len(per_len),
    .state(state), .ready(bit_ready), .accept(accept),
    .cnt_clr(cnt_clr), .cnt_adv(cnt_adv)
  );

  assign drive_low = (state == ST_LOW);

endmodule

// File: rtl/cec_bit_tx_chk.sv
module cec_bit_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       bit_valid,
  input logic       bit_ready,
  input logic       drive_low,
  input logic [1:0] sel_q,
  input logic       busy
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!drive_low && bit_ready));

  // R9
  low_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> !bit_ready);

  // R10
  accept_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_ready) |=> drive_low);

  // R11
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_low && !tick) |=> drive_low);

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sel_q));

endmodule

bind cec_bit_tx cec_bit_tx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bit_valid(bit_valid),
  .bit_ready(bit_ready), .drive_low(drive_low), .sel_q(sel_q), .busy(busy)
);

// File: tb/test_cec_bit_tx.sv
module test_cec_bit_tx;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       bit_valid;
  logic       bit_start;
  logic       bit_value;
  logic [1:0] adv_sel;
  logic       bit_ready;
  logic       drive_low;

  int checks;
  int errors;
  int ready_in_low;
  bit done;

  // sel, start, value, expected low cycles, expected high cycles
  localparam logic [19:0] VEC [12] = '{
    {2'd0, 1'b1, 1'b0, 8'd8, 8'd4},
    {2'd0, 1'b0, 1'b0, 8'd5, 8'd5},
    {2'd0, 1'b0, 1'b1, 8'd2, 8'd8},
    {2'd1, 1'b1, 1'b0, 8'd8, 8'd3},
    {2'd1, 1'b0, 1'b0, 8'd5, 8'd3},
    {2'd1, 1'b0, 1'b1, 8'd2, 8'd6},
    {2'd2, 1'b1, 1'b0, 8'd8, 8'd2},
    {2'd2, 1'b0, 1'b0, 8'd5, 8'd2},
    {2'd2, 1'b0, 1'b1, 8'd2, 8'd5},
    {2'd3, 1'b1, 1'b0, 8'd8, 8'd1},
    {2'd3, 1'b0, 1'b0, 8'd5, 8'd1},
    {2'd3, 1'b0, 1'b1, 8'd2, 8'd4}
  };

  cec_bit_tx #(
    .START_LOW(8), .START_PER(12), .ZERO_LOW(5), .ONE_LOW(2), .DATA_PER(10),
    .START_ADV('{0, 1, 2, 3}), .DATA_ADV('{0, 2, 3, 4})
  ) i_cec_bit_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bit_valid(bit_valid),
    .bit_start(bit_start), .bit_value(bit_value), .adv_sel(adv_sel),
    .bit_ready(bit_ready), .drive_low(drive_low)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Starts at the negedge after acceptance; ends at the negedge where ready was seen.
  task automatic measure(output int lo, output int hi);
    lo = 0;
    hi = 0;
    while (drive_low && lo < 1000) begin
      if (bit_ready) ready_in_low++;
      lo++;
      @(negedge clk);
    end
    while (hi < 1000) begin
      hi++;
      if (bit_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic offer(input logic [1:0] s, input logic st, input logic v);
    adv_sel   = s;
    bit_start = st;
    bit_value = v;
    bit_valid = 1'b1;
  endtask

  initial begin
    int lo, hi;
    checks = 0; errors = 0; ready_in_low = 0; done = 0;
    rst_n = 1'b0; tick = 1'b1; bit_valid = 1'b0;
    bit_start = 1'b0; bit_value = 1'b0; adv_sel = 2'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 drive_low in reset", int'(drive_low), 0);
    check("R1 ready in reset", int'(bit_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 drive_low after reset", int'(drive_low), 0);

    // R2..R7 table sweep
    for (int i = 0; i < 12; i++) begin
      offer(VEC[i][19:18], VEC[i][17], VEC[i][16]);
      @(negedge clk);
      bit_valid = 1'b0;
      measure(lo, hi);
      check(VEC[i][17] ? "R2 start low" : (VEC[i][16] ? "R4 one low" : "R3 zero low"),
            lo, int'(VEC[i][15:8]));
      check(VEC[i][19:18] == 2'd0 ? "R5 period" :
            (VEC[i][17] ? "R6 start period" : "R7 data period"),
            lo + hi, int'(VEC[i][15:8]) + int'(VEC[i][7:0]));
      @(negedge clk);
      check("R9 ready when idle", int'(bit_ready), 1);
    end
    check("R9 ready never in low phase", ready_in_low, 0);

    // R10 back-to-back, R8 select held while busy
    offer(2'd3, 1'b1, 1'b0);
    @(negedge clk);
    offer(2'd0, 1'b0, 1'b1);
    check("R9 ready low mid-bit", int'(bit_ready), 0);
    measure(lo, hi);
    check("R8 first bit period sel3", lo + hi, 9);
    @(negedge clk);
    bit_valid = 1'b0;
    check("R10 no gap between bits", int'(drive_low), 1);
    measure(lo, hi);
    check("R10 second bit low", lo, 2);
    check("R8 select kept while busy", hi, 4);
    @(negedge clk);
    // new burst latches the new select
    offer(2'd0, 1'b0, 1'b1);
    @(negedge clk);
    bit_valid = 1'b0;
    measure(lo, hi);
    check("R8 select taken from idle", hi, 8);
    @(negedge clk);

    // R11 tick stall
    tick = 1'b0;
    offer(2'd0, 1'b1, 1'b0);
    @(negedge clk);
    bit_valid = 1'b0;
    lo = 0;
    for (int k = 0; k < 20; k++) begin
      lo += int'(drive_low);
      @(negedge clk);
    end
    check("R11 low held without tick", lo, 20);
    tick = 1'b1;
    measure(lo, hi);
    check("R11 low ticks after stall", lo, 8);
    check("R11 high ticks after stall", hi, 4);
    @(negedge clk);

    // R1 reset in the middle of a bit
    offer(2'd0, 1'b1, 1'b0);
    @(negedge clk);
    bit_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset releases line", int'(drive_low), 0);
    check("R1 async reset ready", int'(bit_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(drive_low), 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule